// File: doc/BRIEF.md
# Consecutive-Frame Defect Persistence Filter

This block watches two received overhead bytes once per 125 µs frame. The bytes are the line automatic-protection byte (K2) and the path status byte (G1). From each frame it forms two raw defect flags: a line far-end receive failure and a path remote defect. Each flag drives its own up/down persistence counter. A filtered status bit changes state only after the raw flag has disagreed with it for a programmed number of frames in a row. No gap is allowed in that run.

Software programs one 8-bit threshold register per channel through a small register port. The upper nibble of each register sets how many defect frames turn the status on. The lower nibble sets how many clean frames turn it off. Every change of a status bit is also reported as a single-cycle interrupt pulse. Bit 0 of every channel vector is the line far-end failure channel, and bit 1 is the path remote defect channel.

Top module: `dpf_filter_top`

## Requirements
- R1: Line channel (bit 0): a strobed frame is a defect frame when `k2_byte[2:0] == 3'b110`. Every other value of those bits, including `3'b111`, counts as a clean frame. Bits 7:3 are ignored.
- R2: Path channel (bit 1): a strobed frame is a defect frame when `g1_byte[3]` or `g1_byte[2]` is 1. A clean frame has both bits at 0. All other G1 bits are ignored.
- R3: In a threshold register, bits 7:4 hold the activation count A and bits 3:0 hold the deactivation count D. An inactive status sets on the A-th consecutive defect frame. An active status clears on the D-th consecutive clean frame. The new status is visible in the cycle after the clock edge that samples that strobe.
- R4: The run counter restarts at zero on any frame that agrees with the current status: a clean frame while inactive, or a defect frame while active.
- R5: Reset is synchronous and active high. After reset both status bits and both interrupt bits are 0. The line threshold reads 8'h55 (5 and 5), and the path threshold reads 8'hAA (10 and 10).
- R6: A nibble value of 0 acts as 1, so the status changes on the first qualifying frame.
- R7: A register write clears that channel's run counter and leaves its status bit unchanged. If the write falls in the same cycle as a frame strobe, that frame is not counted for the written channel.
- R8: `irq[c]` is high for exactly one cycle, the same cycle in which `status[c]` first shows its new value. This happens on every rise and every fall of the status.
- R9: Counters advance only in cycles where `frame_stb` is high. The overhead bytes are sampled in that same cycle, and they have no effect in any other cycle.
- R10: When `reg_wr` is high, `reg_wdata` is written to the channel chosen by `reg_addr` (0 = line, 1 = path). `reg_rdata` is registered: it shows the threshold of the channel addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| k2_byte | input | 8 | Received K2 overhead byte, valid with `frame_stb` |
| g1_byte | input | 8 | Received G1 overhead byte, valid with `frame_stb` |
| reg_addr | input | ADDR_W (1) | Threshold register select |
| reg_wr | input | 1 | Write enable for the selected threshold |
| reg_wdata | input | 2*NIB_W (8) | Write data: activation nibble high, deactivation nibble low |
| reg_rdata | output | 2*NIB_W (8) | Registered read of the selected threshold |
| status | output | 2 | Filtered defect status per channel |
| irq | output | 2 | One-cycle pulse on every status change |

## Verification
A threshold write and a frame strobe can arrive in the same clock cycle. Both act on the same run counter, and the write wins. The bench first builds a run of two defect frames on the path channel against an activation count of 3. It then issues a write in the same cycle as a third defect frame. It expects the status to stay clear through two further defect frames and to set only on the third frame after the write. If the frame were counted, or the counter kept its value, the status would set earlier.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
  localparam int CH_N   = 2;
  localparam int ADDR_W = (CH_N > 1) ? $clog2(CH_N) : 1;
  localparam int CH_LINE = 0;
  localparam int CH_PATH = 1;

  // frames used for both nibbles after reset, per channel
  function automatic int rst_frames(input int ch);
    return (ch == CH_LINE) ? 5 : 10;
  endfunction
endpackage

// File: rtl/dpf_detect.sv
module dpf_detect
  import dpf_pkg::*;
(
  input  logic [7:0]      k2_i,
  input  logic [7:0]      g1_i,
  output logic [CH_N-1:0] defect_o
);
  logic unused_bits;
  assign unused_bits = ^{k2_i[7:3], g1_i[7:4], g1_i[1:0]};

  always_comb begin
    defect_o          = '0;
    defect_o[CH_LINE] = (k2_i[2:0] == 3'b110);
    defect_o[CH_PATH] = g1_i[3] | g1_i[2];
  end
endmodule

// File: rtl/dpf_regs.sv
module dpf_regs
  import dpf_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int DW = 2 * NIB_W
)(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      wr_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [DW-1:0]             rdata_o,
  output logic [CH_N-1:0][DW-1:0]   thr_o,
  output logic [CH_N-1:0]           wr_ch_o
);
  logic [CH_N-1:0][DW-1:0] thr_q;
  logic [DW-1:0]           rdata_q;

  for (genvar c = 0; c < CH_N; c++) begin : g_thr
    localparam logic [NIB_W-1:0] RST_NIB = NIB_W'(rst_frames(c));
    assign wr_ch_o[c] = wr_i && (addr_i == ADDR_W'(c));
    always_ff @(posedge clk) begin
      if (rst)             thr_q[c] <= {RST_NIB, RST_NIB};
      else if (wr_ch_o[c]) thr_q[c] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= thr_q[addr_i];
  end

  assign thr_o   = thr_q;
  assign rdata_o = rdata_q;

  // R10
  wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> thr_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/dpf_persist.sv
module dpf_persist #(
  parameter int NIB_W = 4,
  localparam int DW = 2 * NIB_W,
  localparam int CW = NIB_W + 1
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_i,
  input  logic          defect_i,
  input  logic          clr_i,
  input  logic [DW-1:0] thr_i,
  output logic          status_o,
  output logic          irq_o
);
  logic [NIB_W-1:0] cnt_q, lim, eff;
  logic [CW-1:0]    cnt_nx;
  logic             status_q, irq_q;

  always_comb begin
    lim    = status_q ? thr_i[NIB_W-1:0] : thr_i[DW-1:NIB_W];
    eff    = (lim == '0) ? NIB_W'(1) : lim;
    cnt_nx = {1'b0, cnt_q} + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (stb_i) begin
        if (defect_i == status_q) begin
          cnt_q <= '0;
        end else if (cnt_nx >= {1'b0, eff}) begin
          status_q <= ~status_q;
          irq_q    <= 1'b1;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_nx[NIB_W-1:0];
        end
      end
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < eff);
  // R7
  wr_clears_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0) && $stable(status_q));
  // R8
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (status_q != $past(status_q)));
  // R9
  no_stb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stb_i |=> $stable(status_q));
  // R3
  rise_on_defect_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q) |-> $past(defect_i && stb_i));
endmodule

// File: rtl/dpf_filter_top.sv
module dpf_filter_top
  import dpf_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int DW = 2 * NIB_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  logic [7:0]        k2_byte,
  input  logic [7:0]        g1_byte,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [CH_N-1:0]   status,
  output logic [CH_N-1:0]   irq
);
  logic [CH_N-1:0]         defect;
  logic [CH_N-1:0][DW-1:0] thr;
  logic [CH_N-1:0]         wr_ch;

  dpf_detect u_detect (
    .k2_i(k2_byte), .g1_i(g1_byte), .defect_o(defect)
  );

  dpf_regs #(.NIB_W(NIB_W)) u_regs (
    .clk(clk), .rst(rst), .addr_i(reg_addr), .wr_i(reg_wr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .thr_o(thr), .wr_ch_o(wr_ch)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    dpf_persist #(.NIB_W(NIB_W)) u_persist (
      .clk(clk), .rst(rst), .stb_i(frame_stb), .defect_i(defect[c]),
      .clr_i(wr_ch[c]), .thr_i(thr[c]),
      .status_o(status[c]), .irq_o(irq[c])
    );
  end
endmodule

// File: tb/tb_dpf_filter_top.sv
module tb_dpf_filter_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_stb = 1'b0;
  logic [7:0] k2_byte = '0, g1_byte = '0;
  logic [0:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] status, irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dpf_filter_top dut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .k2_byte(k2_byte),
    .g1_byte(g1_byte), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status(status), .irq(irq)
  );

  // {k2, g1, expected status, expected irq}; ch0 thr 8'h72, ch1 thr 8'h21
  localparam logic [19:0] VEC [0:14] = '{
    {8'h06, 8'h13, 2'b00, 2'b00},
    {8'h06, 8'h08, 2'b00, 2'b00},
    {8'h07, 8'h04, 2'b10, 2'b10},
    {8'h06, 8'h00, 2'b00, 2'b10},
    {8'h06, 8'h0C, 2'b00, 2'b00},
    {8'h06, 8'h0C, 2'b10, 2'b10},
    {8'h06, 8'h0C, 2'b10, 2'b00},
    {8'h06, 8'h0C, 2'b10, 2'b00},
    {8'h06, 8'h0C, 2'b10, 2'b00},
    {8'h06, 8'h0C, 2'b11, 2'b01},
    {8'h02, 8'h0C, 2'b11, 2'b00},
    {8'hF6, 8'h0C, 2'b11, 2'b00},
    {8'h00, 8'h0C, 2'b11, 2'b00},
    {8'h00, 8'hFC, 2'b10, 2'b01},
    {8'h00, 8'hF3, 2'b00, 2'b10}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // one frame; optional write in the same cycle; samples just after the edge
  task automatic frame(input logic [7:0] k2, input logic [7:0] g1,
                       input logic wr, input logic [0:0] a, input logic [7:0] d);
    @(negedge clk);
    frame_stb = 1'b1; k2_byte = k2; g1_byte = g1;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    frame_stb = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [0:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [0:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    do_reset();
    // R5 reset state
    check("R5 status", {6'd0, status}, 8'h00);
    check("R5 irq", {6'd0, irq}, 8'h00);
    rd_reg(1'b0, rd); check("R5 line thr", rd, 8'h55);
    rd_reg(1'b1, rd); check("R5 path thr", rd, 8'hAA);

    // R3/R5 default counts: line sets on 5th frame, path on 10th
    for (int i = 1; i <= 4; i++) begin
      frame(8'h06, 8'h00, 1'b0, 1'b0, 8'h00);
      check("R1 line before 5", {7'd0, status[0]}, 8'h00);
    end
    frame(8'h06, 8'h08, 1'b0, 1'b0, 8'h00);
    check("R1 line set at 5", {6'd0, status}, 8'h01);
    check("R8 irq line rise", {6'd0, irq}, 8'h01);
    for (int i = 2; i <= 9; i++) begin
      frame(8'h06, 8'h08, 1'b0, 1'b0, 8'h00);
      check("R2 path before 10", {7'd0, status[1]}, 8'h00);
    end
    frame(8'h06, 8'h08, 1'b0, 1'b0, 8'h00);
    check("R2 path set at 10", {6'd0, status}, 8'h03);

    do_reset();
    wr_reg(1'b0, 8'h72);
    wr_reg(1'b1, 8'h21);
    rd_reg(1'b0, rd); check("R10 readback line", rd, 8'h72);
    rd_reg(1'b1, rd); check("R10 readback path", rd, 8'h21);

    // R1 R2 R3 R4 R8 table
    for (int i = 0; i < 15; i++) begin
      frame(VEC[i][19:12], VEC[i][11:4], 1'b0, 1'b0, 8'h00);
      check($sformatf("R3/R4 vec%0d status", i), {6'd0, status}, {6'd0, VEC[i][3:2]});
      check($sformatf("R8 vec%0d irq", i), {6'd0, irq}, {6'd0, VEC[i][1:0]});
      @(negedge clk);
      check($sformatf("R8 vec%0d irq drop", i), {6'd0, irq}, 8'h00);
    end

    // R9: defect bytes held without strobe do not count
    @(negedge clk);
    k2_byte = 8'h06; g1_byte = 8'h0C;
    repeat (20) @(negedge clk);
    check("R9 no strobe", {6'd0, status}, 8'h00);
    for (int i = 1; i <= 6; i++) frame(8'h06, 8'h00, 1'b0, 1'b0, 8'h00);
    check("R9 line after 6", {7'd0, status[0]}, 8'h00);
    frame(8'h06, 8'h00, 1'b0, 1'b0, 8'h00);
    check("R9 line after 7", {7'd0, status[0]}, 8'h01);

    // R6 zero nibbles; R7 write keeps status
    wr_reg(1'b0, 8'h00);
    check("R7 status kept on write", {7'd0, status[0]}, 8'h01);
    frame(8'h00, 8'h00, 1'b0, 1'b0, 8'h00);
    check("R6 clear on first clean", {7'd0, status[0]}, 8'h00);
    frame(8'h06, 8'h00, 1'b0, 1'b0, 8'h00);
    check("R6 set on first defect", {7'd0, status[0]}, 8'h01);

    // R7 write in same cycle as strobe: frame not counted, counter cleared
    wr_reg(1'b1, 8'h31);
    frame(8'h06, 8'h04, 1'b0, 1'b0, 8'h00);
    frame(8'h06, 8'h04, 1'b0, 1'b0, 8'h00);
    check("R7 path before write", {7'd0, status[1]}, 8'h00);
    frame(8'h06, 8'h04, 1'b1, 1'b1, 8'h31);
    check("R7 frame with write", {7'd0, status[1]}, 8'h00);
    frame(8'h06, 8'h04, 1'b0, 1'b0, 8'h00);
    frame(8'h06, 8'h04, 1'b0, 1'b0, 8'h00);
    check("R7 counter restarted", {7'd0, status[1]}, 8'h00);
    frame(8'h06, 8'h04, 1'b0, 1'b0, 8'h00);
    check("R7 set after 3 new", {7'd0, status[1]}, 8'h01);
    check("R8 irq path rise", {6'd0, irq}, 8'h02);
    rd_reg(1'b1, rd); check("R10 path thr", rd, 8'h31);
    rd_reg(1'b0, rd); check("R10 line thr", rd, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule